// File: doc/BRIEF.md
# Alternate-Frame Even/Odd Pixel Sampler

This block halves the number of samples taken per line by keeping only one parity of pixel positions in each frame, and it switches that parity on every frame. Over two successive frames every position of a line has been sampled once. A lower-rate sampler downstream can therefore work at half the pixel rate and still collect a full-resolution image across a pair of frames.

A merge stage beside the sampler keeps a buffer one line wide. Every kept sample is written into the buffer at its pixel position. For each incoming pixel the merge stage emits one pixel of a full-width line. At a kept position this is the live sample. At any other position it is the value stored there by the previous frame. The reconstructed stream therefore runs at the full refresh rate, one output per input pixel.

A phase-invert input reverses the nominal parity. It is sampled only on the start-of-frame pixel, so a change made during a frame waits for the next frame. The control is a three-state machine. `ST_IDLE` is entered at reset and waits for the first start-of-frame pixel; pixels that arrive in it are ignored. Transition *first_sof* leads to `ST_FIRST`, the first frame. Transition *second_sof* leads to `ST_PAIRED`, which holds from then on; in it a pair of frames has been seen. Only reset leaves `ST_PAIRED`.

Top module: `pix_alt_sampler`

## Requirements
- R1: After reset `dec_vld` and `full_vld` are 0. Pixels that arrive before the first start-of-frame pixel produce no output on either stream.
- R2: The pixel index is 0 on any valid pixel with `pix_sol` or `pix_sof` set and rises by one for each following valid pixel. Index 0 counts as even, and parity is bit 0 of the index.
- R3: With `phase_inv` at 0, the first frame after reset keeps even positions, and the kept parity alternates on every later frame.
- R4: With `phase_inv` at 1 on a start-of-frame pixel, that frame keeps the parity opposite to the one the alternation would give.
- R5: `phase_inv` is read only on a valid start-of-frame pixel. A change during a frame has no effect until the next start-of-frame.
- R6: One cycle after a kept pixel, `dec_vld` is 1 and `dec_data` equals that pixel. A dropped pixel raises no `dec_vld`.
- R7: One cycle after every accepted valid pixel, `full_vld` is 1. With no valid input, `full_vld` is 0 one cycle later.
- R8: On the full stream, a kept position carries the live sample. Any other position carries the sample last stored at that index.
- R9: A position whose buffer slot has not been written since reset outputs zero on the full stream.
- R10: `pix_sof` alone, without `pix_sol`, also restarts the pixel index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | DATA_W | Incoming pixel value |
| pix_vld | input | 1 | Pixel value is valid this cycle |
| pix_sol | input | 1 | This pixel is the first of a line |
| pix_sof | input | 1 | This pixel is the first of a frame |
| phase_inv | input | 1 | Reverse the nominal parity for the next frame |
| dec_vld | output | 1 | Decimated sample valid |
| dec_data | output | DATA_W | Decimated sample value |
| full_vld | output | 1 | Reconstructed pixel valid |
| full_data | output | DATA_W | Reconstructed pixel value |

## Verification
The stimulus raises `phase_inv` in the middle of a frame. A design that latches it immediately would flip parity partway through the frame and pass odd samples where even ones belong. Two frames are run with the invert held high, so that a design which toggles parity only on changes of the invert input, instead of XOR-ing it with the alternation, emits the wrong parity. A frame begins with `pix_sof` but no `pix_sol`, and a short line is cut off by a fresh start-of-line; an index that failed to restart would read the wrong slot. After a mid-stream reset, the bench checks that stale slots read as zero and that pixels arriving before the first start-of-frame are ignored.

// File: rtl/pas_pkg.sv
package pas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_PAIRED = 2'd2
    } pas_state_t;

endpackage

// File: rtl/pas_phase_ctrl.sv
module pas_phase_ctrl
    import pas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_vld,
    input  logic       pix_sof,
    input  logic       phase_inv,
    output logic       active,
    output logic       cur_odd,
    output logic       frame_odd,
    output pas_state_t st
);

    pas_state_t st_nxt;
    logic       tog_q;
    logic       frame_odd_q;
    logic       sof_hit;
    logic       odd_now;

    assign sof_hit = pix_vld && pix_sof;
    assign odd_now = tog_q ^ phase_inv;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (sof_hit) st_nxt = ST_FIRST;
            ST_FIRST:  if (sof_hit) st_nxt = ST_PAIRED;
            ST_PAIRED: st_nxt = ST_PAIRED;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            tog_q       <= 1'b0;
            frame_odd_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (sof_hit) begin
                tog_q       <= ~tog_q;
                frame_odd_q <= odd_now;
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_IDLE: begin
                active  = sof_hit;
                cur_odd = odd_now;
            end
            ST_FIRST, ST_PAIRED: begin
                active  = pix_vld;
                cur_odd = sof_hit ? odd_now : frame_odd_q;
            end
            default: begin
                active  = 1'b0;
                cur_odd = 1'b0;
            end
        endcase
    end

    assign frame_odd = frame_odd_q;

endmodule

// File: rtl/pas_pix_index.sv
module pas_pix_index #(
    parameter int LINE_W = 8,
    localparam int IDX_W = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_vld,
    input  logic             pix_sol,
    input  logic             pix_sof,
    output logic [IDX_W-1:0] cur_idx
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINE_W - 1);

    logic [IDX_W-1:0] idx_q;

    assign cur_idx = (pix_sol || pix_sof) ? '0 : idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (pix_vld) begin
            idx_q <= (cur_idx == IDX_LAST) ? IDX_LAST : cur_idx + 1'b1;
        end
    end

endmodule

// File: rtl/pas_merge_buf.sv
module pas_merge_buf #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 8,
    localparam int IDX_W = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              keep,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] pix,
    output logic              dec_vld,
    output logic [DATA_W-1:0] dec_data,
    output logic              full_vld,
    output logic [DATA_W-1:0] full_data
);

    logic [DATA_W-1:0] mem [LINE_W];
    logic [LINE_W-1:0] slot_ok;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] merged;
    logic              wr;

    assign wr = en && keep;

    for (genvar g = 0; g < LINE_W; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr && idx == IDX_W'(g)) mem[g] <= pix;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)                      slot_ok[g] <= 1'b0;
            else if (wr && idx == IDX_W'(g)) slot_ok[g] <= 1'b1;
        end
    end

    always_comb begin
        stored = slot_ok[idx] ? mem[idx] : '0;
        merged = keep ? pix : stored;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld   <= 1'b0;
            dec_data  <= '0;
            full_vld  <= 1'b0;
            full_data <= '0;
        end else begin
            dec_vld  <= wr;
            full_vld <= en;
            if (wr) dec_data  <= pix;
            if (en) full_data <= merged;
        end
    end

endmodule

// File: rtl/pix_alt_sampler.sv
module pix_alt_sampler
    import pas_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              pix_vld,
    input  logic              pix_sol,
    input  logic              pix_sof,
    input  logic              phase_inv,
    output logic              dec_vld,
    output logic [DATA_W-1:0] dec_data,
    output logic              full_vld,
    output logic [DATA_W-1:0] full_data
);

    localparam int IDX_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;

    pas_state_t       st;
    logic             active;
    logic             cur_odd;
    logic             frame_odd;
    logic             keep;
    logic [IDX_W-1:0] cur_idx;

    pas_phase_ctrl u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_vld   (pix_vld),
        .pix_sof   (pix_sof),
        .phase_inv (phase_inv),
        .active    (active),
        .cur_odd   (cur_odd),
        .frame_odd (frame_odd),
        .st        (st)
    );

    pas_pix_index #(.LINE_W(LINE_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_vld (pix_vld),
        .pix_sol (pix_sol),
        .pix_sof (pix_sof),
        .cur_idx (cur_idx)
    );

    assign keep = (cur_idx[0] == cur_odd);

    pas_merge_buf #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .keep      (keep),
        .idx       (cur_idx),
        .pix       (pix_in),
        .dec_vld   (dec_vld),
        .dec_data  (dec_data),
        .full_vld  (full_vld),
        .full_data (full_data)
    );

endmodule

// File: rtl/pas_checker.sv
module pas_checker
    import pas_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_vld,
    input logic              pix_sof,
    input logic              dec_vld,
    input logic [DATA_W-1:0] dec_data,
    input logic              full_vld,
    input logic [DATA_W-1:0] full_data,
    input pas_state_t        st,
    input logic              frame_odd
);

    a_r6_dec_has_full: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> full_vld);

    a_r8_kept_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> (full_data == dec_data));

    a_r7_idle_input_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> !full_vld);

    a_r7_sof_gives_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_sof) |=> full_vld);

    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(pix_vld && pix_sof)) |=> (!full_vld && !dec_vld));

    a_r5_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_vld && pix_sof) |=> $stable(frame_odd));

    a_r3_paired_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAIRED) |=> (st == ST_PAIRED));

endmodule

bind pix_alt_sampler pas_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_vld   (pix_vld),
    .pix_sof   (pix_sof),
    .dec_vld   (dec_vld),
    .dec_data  (dec_data),
    .full_vld  (full_vld),
    .full_data (full_data),
    .st        (st),
    .frame_odd (frame_odd)
);

// File: tb/pix_alt_sampler_bench.sv
module pix_alt_sampler_bench;

    localparam int DATA_W = 8;
    localparam int LINE_W = 8;
    localparam int NVEC   = 28;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] pix_in = '0;
    logic              pix_vld = 1'b0;
    logic              pix_sol = 1'b0;
    logic              pix_sof = 1'b0;
    logic              phase_inv = 1'b0;
    logic              dec_vld;
    logic [DATA_W-1:0] dec_data;
    logic              full_vld;
    logic [DATA_W-1:0] full_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pix_alt_sampler #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_pix_alt_sampler (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld),
        .pix_sol(pix_sol), .pix_sof(pix_sof), .phase_inv(phase_inv),
        .dec_vld(dec_vld), .dec_data(dec_data),
        .full_vld(full_vld), .full_data(full_data)
    );

    // {vld, sof, sol, inv, data, exp_dvld, exp_ddata, exp_fvld, exp_fdata}
    localparam logic [29:0] VEC [NVEC] = '{
        {4'b1000, 8'h55, 1'b0, 8'h00, 1'b0, 8'h00}, // R1 before first sof
        {4'b1100, 8'h10, 1'b1, 8'h10, 1'b1, 8'h10}, // R3 frame A even
        {4'b1000, 8'h11, 1'b0, 8'h00, 1'b1, 8'h00}, // R9
        {4'b1000, 8'h12, 1'b1, 8'h12, 1'b1, 8'h12},
        {4'b1000, 8'h13, 1'b0, 8'h00, 1'b1, 8'h00},
        {4'b1010, 8'h18, 1'b1, 8'h18, 1'b1, 8'h18}, // R2 sol
        {4'b1000, 8'h19, 1'b0, 8'h00, 1'b1, 8'h00},
        {4'b1000, 8'h1A, 1'b1, 8'h1A, 1'b1, 8'h1A},
        {4'b1000, 8'h1B, 1'b0, 8'h00, 1'b1, 8'h00},
        {4'b1100, 8'h20, 1'b0, 8'h00, 1'b1, 8'h18}, // R10 R3 frame B odd
        {4'b1000, 8'h21, 1'b1, 8'h21, 1'b1, 8'h21},
        {4'b1000, 8'h22, 1'b0, 8'h00, 1'b1, 8'h1A}, // R8
        {4'b1000, 8'h23, 1'b1, 8'h23, 1'b1, 8'h23},
        {4'b1011, 8'h28, 1'b0, 8'h00, 1'b1, 8'h18}, // R5 inv mid-frame
        {4'b1001, 8'h29, 1'b1, 8'h29, 1'b1, 8'h29},
        {4'b1001, 8'h2A, 1'b0, 8'h00, 1'b1, 8'h1A},
        {4'b1001, 8'h2B, 1'b1, 8'h2B, 1'b1, 8'h2B},
        {4'b1101, 8'h30, 1'b0, 8'h00, 1'b1, 8'h18}, // R4 frame C odd
        {4'b1001, 8'h31, 1'b1, 8'h31, 1'b1, 8'h31},
        {4'b1001, 8'h32, 1'b0, 8'h00, 1'b1, 8'h1A},
        {4'b1001, 8'h33, 1'b1, 8'h33, 1'b1, 8'h33},
        {4'b1101, 8'h40, 1'b1, 8'h40, 1'b1, 8'h40}, // R4 frame D even
        {4'b0001, 8'h77, 1'b0, 8'h00, 1'b0, 8'h00}, // R7 gap
        {4'b1001, 8'h41, 1'b0, 8'h00, 1'b1, 8'h31}, // R8
        {4'b1001, 8'h42, 1'b1, 8'h42, 1'b1, 8'h42}, // R6
        {4'b1001, 8'h43, 1'b0, 8'h00, 1'b1, 8'h33},
        {4'b1011, 8'h50, 1'b1, 8'h50, 1'b1, 8'h50}, // R2 short line
        {4'b1001, 8'h51, 1'b0, 8'h00, 1'b1, 8'h31}
    };

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic f, input logic s,
                         input logic inv, input logic [DATA_W-1:0] d);
        pix_vld = v; pix_sof = f; pix_sol = s; phase_inv = inv; pix_in = d;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset dec_vld", 8'(dec_vld), 8'h00);
        chk("R1 reset full_vld", 8'(full_vld), 8'h00);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][29], VEC[k][28], VEC[k][27], VEC[k][26], VEC[k][25:18]);
            chk($sformatf("R6 dec_vld vec%0d", k), 8'(dec_vld), 8'(VEC[k][17]));
            if (VEC[k][17])
                chk($sformatf("R6 dec_data vec%0d", k), dec_data, VEC[k][16:9]);
            chk($sformatf("R7 full_vld vec%0d", k), 8'(full_vld), 8'(VEC[k][8]));
            if (VEC[k][8])
                chk($sformatf("R8 full_data vec%0d", k), full_data, VEC[k][7:0]);
        end

        // R1: reset in the middle of a run clears both streams
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h66);
        chk("R1 mid reset dec_vld", 8'(dec_vld), 8'h00);
        chk("R1 mid reset full_vld", 8'(full_vld), 8'h00);
        rst_n = 1'b1;

        // R1: pixel with no preceding sof is ignored
        drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h67);
        chk("R1 pre-sof full_vld", 8'(full_vld), 8'h00);

        // R3: phase restarts at even after reset
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h60);
        chk("R3 even after reset dec_vld", 8'(dec_vld), 8'h01);
        chk("R3 even after reset dec_data", dec_data, 8'h60);

        // R9: slot 1 was written before reset but reads zero now
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h61);
        chk("R9 cleared slot full_vld", 8'(full_vld), 8'h01);
        chk("R9 cleared slot full_data", full_data, 8'h00);
        chk("R6 dropped dec_vld", 8'(dec_vld), 8'h00);

        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R7 idle full_vld", 8'(full_vld), 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule